// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo serial audio stream (bit clock, word select and one data line) from an external source. It oversamples all three lines inside a faster system clock domain and rebuilds parallel left and right samples of up to 20 bits. The block is a slave only: it never drives the bit clock or the word select. It only watches their edges.

A 3-bit format code selects how a sample sits inside each channel half. In I2S framing the MSB comes one bit slot after the word-select change. In MSB-justified framing the MSB comes in the first slot. In the LSB-justified framings the sample ends on the last slot before the next word-select change, so the block counts back from that edge by 16, 18 or 20 bits. Samples come out left-aligned in a 20-bit field, and both channels are presented together with a one-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, `leftOut` and `rightOut` are zero and `sampleValid` is low.
- R2: Format code 000 (I2S): the first bit sampled on the second rising bit-clock edge after a word-select change is the sample MSB, and the following bits come MSB first.
- R3: Format code 100 (MSB-justified): the bit sampled on the first rising bit-clock edge after a word-select change is the sample MSB, and the following bits come MSB first.
- R4: Format code 001: the last 16 bits before a word-select change form the sample. They appear in bits [19:4], and bits [3:0] are zero. Earlier bits in the half are ignored.
- R5: Format code 010: the last 18 bits before a word-select change appear in bits [19:2], and bits [1:0] are zero.
- R6: Format code 011: the last 20 bits before a word-select change form the whole 20-bit sample.
- R7: Format codes 101, 110 and 111 behave exactly as code 000.
- R8: Word select low carries the left channel and high carries the right channel. `sampleValid` pulses for one system clock cycle once the right word has ended, which is seen at the first rising bit-clock edge of the next left half. The pulse carries that frame's left and right samples.
- R9: An I2S or MSB-justified word shorter than 20 bits, followed by zero slots, comes out left-aligned with zeros in the unused low bits.
- R10: In I2S and MSB-justified framing, bits after the 20th bit of a word have no effect on the output.
- R11: The format code is taken at the start of each word. A change of code while a word is being received does not affect how that word is assembled.
- R12: `leftOut` and `rightOut` change only in the cycle in which `sampleValid` is high, and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClkIn | input | 1 | Serial bit clock from the audio source |
| wordSelIn | input | 1 | Word select: low is left, high is right |
| dataIn | input | 1 | Serial data, sampled on bit-clock rising edges |
| fmtSel | input | 3 | Framing format code |
| leftOut | output | 20 | Left sample, left-aligned |
| rightOut | output | 20 | Right sample, left-aligned |
| sampleValid | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
On every cycle, the in-RTL assertions check four things: the single-cycle strobe, that the outputs hold between strobes, that bit-slot counting restarts at each word boundary, and that the latched word format stays put inside a word. Which bits land where can only be shown by the bench's frames. Those frames cover each format code with leading or trailing filler bits, short and over-long words, different half lengths for the LSB-justified modes, unused codes, and format changes between frames.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'b000,
    FMT_LSB16 = 3'b001,
    FMT_LSB18 = 3'b010,
    FMT_LSB20 = 3'b011,
    FMT_MSBJ  = 3'b100
  } fmt_e;

  localparam int LEN16 = 16;
  localparam int LEN18 = 18;
  localparam int LEN20 = 20;

  // Strobes from control to datapath, valid in the cycle a bit-clock rise is seen.
  typedef struct packed {
    logic bitStrobe;   // rising bit-clock edge detected
    logic bitVal;      // data bit sampled at that edge
    logic wordStart;   // word select changed at this edge
    logic wordEnd;     // a complete word (after arming) finishes here
    logic endRight;    // the finishing word belonged to the right channel
    fmt_e endFmt;      // format the finishing word was received with
    logic msbWrite;    // store bitVal into the MSB-first word
  } strobe_t;

endpackage

// File: rtl/asrx_ctrl.sv
module asrx_ctrl
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = 6,
  localparam int IDX_W      = $clog2(SAMPLE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClkIn,
  input  logic             wordSelIn,
  input  logic             dataIn,
  input  logic [2:0]       fmtSel,
  output strobe_t          strb,
  output logic [IDX_W-1:0] msbIdx
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] WLIM     = SLOT_W'(SAMPLE_W);

  logic [SYNC_STAGES-1:0][2:0] syncPipe;
  logic bclkS, wsS, dataS, bclkPrev;
  logic wsPrev, armed;
  logic [SLOT_W-1:0] slotCnt, curSlot, pos;
  fmt_e wordFmt, newFmt;
  logic rise, boundary, isI2s, isMsbj, posOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe <= '0;
      bclkPrev <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], {bitClkIn, wordSelIn, dataIn}};
      bclkPrev <= bclkS;
    end
  end

  assign {bclkS, wsS, dataS} = syncPipe[SYNC_STAGES-1];

  function automatic fmt_e decodeFmt(input logic [2:0] code);
    case (code)
      3'b001:  return FMT_LSB16;
      3'b010:  return FMT_LSB18;
      3'b011:  return FMT_LSB20;
      3'b100:  return FMT_MSBJ;
      default: return FMT_I2S;
    endcase
  endfunction

  always_comb begin
    rise     = bclkS & ~bclkPrev;
    boundary = rise & (wsS != wsPrev);
    if (boundary)               curSlot = '0;
    else if (slotCnt == SLOT_MAX) curSlot = SLOT_MAX;
    else                        curSlot = slotCnt + SLOT_W'(1);
    newFmt = boundary ? decodeFmt(fmtSel) : wordFmt;
    isI2s  = (newFmt == FMT_I2S);
    isMsbj = (newFmt == FMT_MSBJ);
    pos    = curSlot - SLOT_W'(isI2s);
    posOk  = (isI2s ? (curSlot != '0) : isMsbj) && (pos < WLIM);
    msbIdx = IDX_W'(WLIM - SLOT_W'(1) - pos);

    strb.bitStrobe = rise;
    strb.bitVal    = dataS;
    strb.wordStart = boundary;
    strb.wordEnd   = boundary & armed;
    strb.endRight  = wsPrev;
    strb.endFmt    = wordFmt;
    strb.msbWrite  = rise & posOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wsPrev  <= 1'b0;
      armed   <= 1'b0;
      slotCnt <= '0;
      wordFmt <= FMT_I2S;
    end else if (rise) begin
      wsPrev  <= wsS;
      slotCnt <= curSlot;
      if (boundary) begin
        armed   <= 1'b1;
        wordFmt <= newFmt;
      end
    end
  end

  // R2/R3: slot counting restarts at every word boundary
  a_r2_slot_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordStart |=> (slotCnt == '0));

  // R11: the word format only moves at a word boundary
  a_r11_fmt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wordStart |=> $stable(wordFmt));

  // R8: two bit-clock rises are never seen in consecutive cycles
  a_r8_edge_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitStrobe |=> !strb.bitStrobe);

endmodule

// File: rtl/asrx_dpath.sv
module asrx_dpath
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [IDX_W-1:0]    msbIdx,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  logic [SAMPLE_W-1:0] msbWord, msbNext, lsbShift, leftHold, doneWord;
  logic leftHave;

  always_comb begin
    case (strb.endFmt)
      FMT_LSB16: doneWord = lsbShift << (SAMPLE_W - LEN16);
      FMT_LSB18: doneWord = lsbShift << (SAMPLE_W - LEN18);
      FMT_LSB20: doneWord = lsbShift << (SAMPLE_W - LEN20);
      default:   doneWord = msbWord;
    endcase
    msbNext = strb.wordStart ? '0 : msbWord;
    if (strb.msbWrite) msbNext[msbIdx] = strb.bitVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msbWord     <= '0;
      lsbShift    <= '0;
      leftHold    <= '0;
      leftHave    <= 1'b0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      msbWord     <= msbNext;
      if (strb.bitStrobe) lsbShift <= {lsbShift[SAMPLE_W-2:0], strb.bitVal};
      if (strb.wordEnd) begin
        if (!strb.endRight) begin
          leftHold <= doneWord;
          leftHave <= 1'b1;
        end else if (leftHave) begin
          leftOut     <= leftHold;
          rightOut    <= doneWord;
          sampleValid <= 1'b1;
          leftHave    <= 1'b0;
        end
      end
    end
  end

  // R8: strobe lasts one cycle
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R12: outputs move only together with the strobe
  a_r12_left_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(leftOut) |-> sampleValid);
  a_r12_right_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rightOut) |-> sampleValid);

  // R10: control never addresses a bit outside the sample field
  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.msbWrite |-> (int'(msbIdx) < SAMPLE_W));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClkIn,
  input  logic                wordSelIn,
  input  logic                dataIn,
  input  logic [2:0]          fmtSel,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  strobe_t          strb;
  logic [IDX_W-1:0] msbIdx;

  asrx_ctrl #(
    .SAMPLE_W(SAMPLE_W), .SYNC_STAGES(SYNC_STAGES), .SLOT_W(SLOT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClkIn), .wordSelIn(wordSelIn),
    .dataIn(dataIn), .fmtSel(fmtSel), .strb(strb), .msbIdx(msbIdx)
  );

  asrx_dpath #(.SAMPLE_W(SAMPLE_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .msbIdx(msbIdx),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClkIn = 1'b0;
  logic        wordSelIn = 1'b1;
  logic        dataIn = 1'b0;
  logic [2:0]  fmtSel = 3'b000;
  logic [19:0] leftOut, rightOut;
  logic        sampleValid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [39:0] expQ[$];
  string       tagQ[$];
  logic [39:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx i_audio_serial_rx (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClkIn), .wordSelIn(wordSelIn),
    .dataIn(dataIn), .fmtSel(fmtSel), .leftOut(leftOut),
    .rightOut(rightOut), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lsbLen(input logic [2:0] f);
    case (f)
      3'b001:  return 16;
      3'b010:  return 18;
      3'b011:  return 20;
      default: return 0;
    endcase
  endfunction

  function automatic logic [19:0] expWord(input logic [2:0] f,
                                          input logic [31:0] v, input int bits);
    int n = lsbLen(f);
    logic [31:0] m;
    if (n > 0) begin
      m = v & ((32'd1 << n) - 32'd1);
      return 20'(m << (20 - n));
    end
    if (bits <= 20) return 20'(v << (20 - bits));
    return 20'(v >> (bits - 20));
  endfunction

  // slot s carries pat[63-s]
  function automatic logic [63:0] buildHalf(input logic [2:0] f, input int slots,
                                            input logic [31:0] v, input int bits);
    logic [63:0] pat = '0;
    int n = lsbLen(f);
    if (n > 0) begin
      for (int s = 0; s < slots - n; s++) pat[63-s] = 1'b1;
      for (int i = 0; i < n; i++) pat[63-(slots-n)-i] = v[n-1-i];
    end else if (f == 3'b100) begin
      for (int i = 0; i < bits; i++) pat[63-i] = v[bits-1-i];
    end else begin
      pat[63] = 1'b1;
      for (int i = 0; i < bits; i++) pat[62-i] = v[bits-1-i];
    end
    return pat;
  endfunction

  task automatic sendHalf(input logic ws, input int slots, input logic [63:0] pat);
    for (int s = 0; s < slots; s++) begin
      @(negedge clk);
      bitClkIn  = 1'b0;
      wordSelIn = ws;
      dataIn    = pat[63-s];
      repeat (HALF_BCK) @(negedge clk);
      bitClkIn = 1'b1;
      repeat (HALF_BCK - 1) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input logic [2:0] f, input int slots,
                           input logic [31:0] l, input logic [31:0] r,
                           input int bits, input string tag);
    fmtSel = f;
    expQ.push_back({expWord(f, l, bits), expWord(f, r, bits)});
    tagQ.push_back(tag);
    sendHalf(1'b0, slots, buildHalf(f, slots, l, bits));
    sendHalf(1'b1, slots, buildHalf(f, slots, r, bits));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", {leftOut, rightOut}, '0);
      end else begin
        logic [39:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        lastExp = e;
        check({leftOut, rightOut} == e, t, {leftOut, rightOut}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(leftOut == '0 && rightOut == '0 && !sampleValid, "R1 reset",
          {leftOut, rightOut}, '0);
    sendHalf(1'b1, 2, '0); // preamble right half

    sendFrame(3'b000, 32, 32'h0A5C3, 32'h03C5A, 16, "R2/R9 i2s 16b");
    sendFrame(3'b000, 32, 32'hF1234, 32'h0ABCD, 20, "R2 i2s 20b");
    sendFrame(3'b000, 32, 32'hABCDEF, 32'h123457, 24, "R10 i2s 24b");
    sendFrame(3'b100, 32, 32'h80001, 32'h7FFFE, 20, "R3/R11 msbj 20b");
    sendFrame(3'b100, 32, 32'h2AAAB, 32'h15555, 18, "R3/R9 msbj 18b");
    sendFrame(3'b100, 32, 32'hFEDCBA, 32'h010203, 24, "R10 msbj 24b");
    sendFrame(3'b001, 32, 32'h0BEEF, 32'h0F00D, 16, "R4/R11 lsb16 32 slots");
    sendFrame(3'b001, 16, 32'h08001, 32'h07FFE, 16, "R4 lsb16 16 slots");
    sendFrame(3'b010, 32, 32'h2C0DE, 32'h1ACE5, 18, "R5 lsb18 32 slots");
    sendFrame(3'b010, 24, 32'h3FFFF, 32'h00001, 18, "R5 lsb18 24 slots");
    sendFrame(3'b011, 32, 32'hC3A5F, 32'h5A3C0, 20, "R6 lsb20 32 slots");
    sendFrame(3'b011, 20, 32'h00000, 32'hFFFFF, 20, "R6 lsb20 20 slots");
    sendFrame(3'b101, 32, 32'h9ABCD, 32'h13579, 20, "R7 code 101");
    sendFrame(3'b110, 32, 32'h2468A, 32'hFDB97, 20, "R7 code 110");
    sendFrame(3'b111, 32, 32'h11111, 32'hEEEEE, 20, "R7 code 111");
    sendFrame(3'b000, 32, 32'hFFFFF, 32'h00000, 20, "R8 left/right split");

    sendHalf(1'b0, 1, '0); // closes the last right word
    repeat (40) @(negedge clk);
    check(expQ.size() == 0, "R8 all pairs delivered", 40'(expQ.size()), '0);
    // R12 outputs hold after the last strobe
    check({leftOut, rightOut} == lastExp, "R12 hold", {leftOut, rightOut}, lastExp);
    check(!sampleValid, "R8 strobe idle", 40'(sampleValid), '0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule